// File: doc/BRIEF.md
# Register-File Port Grant Arbiter

This block decides which of several function units may use the register file's read port and which may use its write port in a given cycle. Each unit presents a binary source register number with a read-pending flag, a binary destination register number with a write-pending flag, and a completion flag that says its result is ready.

Every register number is decoded to one-hot form. The one-hot vectors of all units with a pending request are ORed into two reservation maps, one for reads and one for writes. Two independent fixed-priority pickers then grant the ports. The lowest-numbered requesting unit wins each port. The write picker only sees units whose result is done.

The maps are always combinational. A parameter selects whether the grants leave combinationally or through one register stage. Hazard detection between units and the register contents are handled elsewhere.

Top module: `rf_port_arbiter`

## Requirements
- R1: Bit r of `rd_resv_o` is 1 exactly when at least one unit u has `src_pend_i[u]`=1 and `src_reg_i[u]`=r.
- R2: Bit r of `wr_resv_o` is 1 exactly when at least one unit u has `dst_pend_i[u]`=1 and `dst_reg_i[u]`=r. The completion flag does not affect this map.
- R3: A unit whose pending flag is 0 contributes no bit to the corresponding map, whatever register number it presents. An immediate operand is signalled this way.
- R4: `rd_grant_o` is one-hot or zero. Its bit is set for the lowest-numbered unit with `src_pend_i` high (bit u = unit u).
- R5: `wr_grant_o` is one-hot or zero. Its bit is set for the lowest-numbered unit with both `dst_pend_i` and `done_i` high.
- R6: A unit never receives a write grant while its `done_i` is low. In registered mode, `done_i` is the value of the cycle whose requests produced the grant.
- R7: The two pickers are independent. One unit may hold both grants in the same cycle, and a unit stuck requesting the read port does not change the write grant.
- R8: With no pending requests, both maps and both grants are zero.
- R9: With `GRANT_MODE`=GRANT_REG, each grant equals the combinational grant of the previous cycle. While `rst_ni` is low, both grants are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used in registered mode) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_reg_i | input | NUM_UNITS x REG_W | Source register number per unit |
| src_pend_i | input | NUM_UNITS | Read request pending per unit |
| dst_reg_i | input | NUM_UNITS x REG_W | Destination register number per unit |
| dst_pend_i | input | NUM_UNITS | Write request pending per unit |
| done_i | input | NUM_UNITS | Result ready (release request) per unit |
| rd_resv_o | output | NUM_REGS | Read-reservation map |
| wr_resv_o | output | NUM_REGS | Write-reservation map |
| rd_grant_o | output | NUM_UNITS | One-hot read-port grant |
| wr_grant_o | output | NUM_UNITS | One-hot write-port grant |

## Verification
The assertions check on every cycle that both grants are one-hot or zero, that each grant only reaches a requester, that no write grant reaches a unit that is not done, and that the maps are empty and have no more bits than there are requests. Only the bench scenarios can show the exact values: which unit wins by priority, the exact bit pattern of each map when registers overlap, the one-cycle delay and reset value of registered grants, and that write grants still follow the done flags while unit 0 keeps its read request high.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic {
    GRANT_COMB = 1'b0,
    GRANT_REG  = 1'b1
  } grant_mode_e;

  localparam int unsigned DEF_UNITS = 4;
  localparam int unsigned DEF_REGS  = 32;
endpackage

// File: rtl/rfa_onehot_dec.sv
module rfa_onehot_dec #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic [REG_W-1:0]    sel_i,
  input  logic                en_i,
  output logic [NUM_REGS-1:0] vec_o
);
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      vec_o[r] = en_i && (sel_i == REG_W'(r));
    end
  end
endmodule

// File: rtl/rfa_resv_map.sv
module rfa_resv_map #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned REG_W     = $clog2(NUM_REGS)
) (
  input  logic [NUM_UNITS-1:0][REG_W-1:0] sel_i,
  input  logic [NUM_UNITS-1:0]            en_i,
  output logic [NUM_REGS-1:0]             map_o
);
  logic [NUM_UNITS-1:0][NUM_REGS-1:0] unary;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    rfa_onehot_dec #(
      .NUM_REGS(NUM_REGS),
      .REG_W   (REG_W)
    ) u_dec (
      .sel_i(sel_i[u]),
      .en_i (en_i[u]),
      .vec_o(unary[u])
    );
  end

  always_comb begin
    map_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      map_o = map_o | unary[u];
    end
  end
endmodule

// File: rtl/rfa_prio_pick.sv
module rfa_prio_pick #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfa_grant_stage.sv
module rfa_grant_stage
  import rfa_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter grant_mode_e GRANT_MODE = GRANT_COMB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (GRANT_MODE == GRANT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/rf_port_arbiter.sv
module rf_port_arbiter
  import rfa_pkg::*;
#(
  parameter int unsigned NUM_UNITS  = DEF_UNITS,
  parameter int unsigned NUM_REGS   = DEF_REGS,
  parameter int unsigned REG_W      = $clog2(NUM_REGS),
  parameter grant_mode_e GRANT_MODE = GRANT_COMB
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] src_reg_i,
  input  logic [NUM_UNITS-1:0]            src_pend_i,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] dst_reg_i,
  input  logic [NUM_UNITS-1:0]            dst_pend_i,
  input  logic [NUM_UNITS-1:0]            done_i,
  output logic [NUM_REGS-1:0]             rd_resv_o,
  output logic [NUM_REGS-1:0]             wr_resv_o,
  output logic [NUM_UNITS-1:0]            rd_grant_o,
  output logic [NUM_UNITS-1:0]            wr_grant_o
);
  localparam int unsigned GW = 2 * NUM_UNITS;

  logic [NUM_UNITS-1:0] wr_cand;
  logic [NUM_UNITS-1:0] rd_pick, wr_pick;
  logic [GW-1:0]        gnt_q;

  rfa_resv_map #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rd_map (
    .sel_i(src_reg_i), .en_i(src_pend_i), .map_o(rd_resv_o)
  );

  rfa_resv_map #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_wr_map (
    .sel_i(dst_reg_i), .en_i(dst_pend_i), .map_o(wr_resv_o)
  );

  // write only once the result is ready
  assign wr_cand = dst_pend_i & done_i;

  rfa_prio_pick #(.WIDTH(NUM_UNITS)) u_rd_pick (.req_i(src_pend_i), .gnt_o(rd_pick));
  rfa_prio_pick #(.WIDTH(NUM_UNITS)) u_wr_pick (.req_i(wr_cand),    .gnt_o(wr_pick));

  rfa_grant_stage #(.WIDTH(GW), .GRANT_MODE(GRANT_MODE)) u_gnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_pick, rd_pick}),
    .q_o   (gnt_q)
  );

  assign rd_grant_o = gnt_q[NUM_UNITS-1:0];
  assign wr_grant_o = gnt_q[GW-1:NUM_UNITS];
endmodule

// File: rtl/rfa_checker.sv
module rfa_checker
  import rfa_pkg::*;
#(
  parameter int unsigned NUM_UNITS  = 4,
  parameter int unsigned NUM_REGS   = 32,
  parameter grant_mode_e GRANT_MODE = GRANT_COMB
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_UNITS-1:0] src_pend_i,
  input logic [NUM_UNITS-1:0] dst_pend_i,
  input logic [NUM_UNITS-1:0] done_i,
  input logic [NUM_REGS-1:0]  rd_resv_o,
  input logic [NUM_REGS-1:0]  wr_resv_o,
  input logic [NUM_UNITS-1:0] rd_grant_o,
  input logic [NUM_UNITS-1:0] wr_grant_o
);
  p_rd_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_grant_o));

  p_wr_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_grant_o));

  p_rd_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_pend_i == '0) |-> (rd_resv_o == '0));

  p_wr_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_pend_i == '0) |-> (wr_resv_o == '0));

  p_rd_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_resv_o) <= $countones(src_pend_i));

  p_wr_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_resv_o) <= $countones(dst_pend_i));

  if (GRANT_MODE == GRANT_REG) begin : g_reg
    p_wr_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_grant_o & ~$past(done_i & dst_pend_i)) == '0);
    p_rd_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_grant_o & ~$past(src_pend_i)) == '0);
  end else begin : g_comb
    p_wr_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_grant_o & ~(done_i & dst_pend_i)) == '0);
    p_rd_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_grant_o & ~src_pend_i) == '0);
    p_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_pend_i == '0 && dst_pend_i == '0) |-> (rd_grant_o == '0 && wr_grant_o == '0));
  end
endmodule

bind rf_port_arbiter rfa_checker #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_REGS  (NUM_REGS),
  .GRANT_MODE(GRANT_MODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_pend_i(src_pend_i),
  .dst_pend_i(dst_pend_i),
  .done_i    (done_i),
  .rd_resv_o (rd_resv_o),
  .wr_resv_o (wr_resv_o),
  .rd_grant_o(rd_grant_o),
  .wr_grant_o(wr_grant_o)
);

// File: tb/tb_rf_port_arbiter.sv
`timescale 1ns/1ps
module tb_rf_port_arbiter;
  import rfa_pkg::*;
  localparam int N = 4;
  localparam int R = 32;
  localparam int W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic [N-1:0][W-1:0] src_reg, dst_reg;
  logic [N-1:0] src_pend, dst_pend, done;
  logic [R-1:0] rd_map, wr_map, rd_map_q, wr_map_q;
  logic [N-1:0] rd_g, wr_g, rd_g_q, wr_g_q;

  rf_port_arbiter #(.NUM_UNITS(N), .NUM_REGS(R)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_reg_i(src_reg), .src_pend_i(src_pend),
    .dst_reg_i(dst_reg), .dst_pend_i(dst_pend), .done_i(done),
    .rd_resv_o(rd_map), .wr_resv_o(wr_map), .rd_grant_o(rd_g), .wr_grant_o(wr_g)
  );

  rf_port_arbiter #(.NUM_UNITS(N), .NUM_REGS(R), .GRANT_MODE(GRANT_REG)) dut_q (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_reg_i(src_reg), .src_pend_i(src_pend),
    .dst_reg_i(dst_reg), .dst_pend_i(dst_pend), .done_i(done),
    .rd_resv_o(rd_map_q), .wr_resv_o(wr_map_q), .rd_grant_o(rd_g_q), .wr_grant_o(wr_g_q)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] prev_rg = '0, prev_wg = '0;

  function automatic logic [R-1:0] ref_map(input logic [N-1:0][W-1:0] sel,
                                           input logic [N-1:0] pend);
    logic [R-1:0] m = '0;
    for (int u = 0; u < N; u++) if (pend[u]) m[sel[u]] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] ref_pick(input logic [N-1:0] req);
    for (int u = 0; u < N; u++) if (req[u]) return N'(1) << u;
    return '0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [R-1:0] er, ew;
    logic [N-1:0] eg, fg;
    er = ref_map(src_reg, src_pend);
    ew = ref_map(dst_reg, dst_pend);
    eg = ref_pick(src_pend);
    fg = ref_pick(dst_pend & done);
    chk({tag, "/R1"}, "rd_resv", 64'(rd_map), 64'(er));
    chk({tag, "/R2"}, "wr_resv", 64'(wr_map), 64'(ew));
    chk({tag, "/R4"}, "rd_grant", 64'(rd_g), 64'(eg));
    chk({tag, "/R5"}, "wr_grant", 64'(wr_g), 64'(fg));
    chk({tag, "/R6"}, "wr_grant&~done", 64'(wr_g & ~done), 64'(0));
    chk({tag, "/R9"}, "rd_grant_q", 64'(rd_g_q), 64'(eg));
    chk({tag, "/R9"}, "wr_grant_q", 64'(wr_g_q), 64'(fg));
    chk({tag, "/R1"}, "rd_resv_q", 64'(rd_map_q), 64'(er));
    prev_rg = eg;
    prev_wg = fg;
  endtask

  // inputs set just after a negedge; checks before and after the next edge
  task automatic cycle(input string tag);
    #1;
    chk({tag, "/R9"}, "rd_grant_q delayed", 64'(rd_g_q), 64'(prev_rg));
    chk({tag, "/R9"}, "wr_grant_q delayed", 64'(wr_g_q), 64'(prev_wg));
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic set_unit(input int u, input logic sp, input logic [W-1:0] sr,
                          input logic dp, input logic [W-1:0] dr, input logic dn);
    src_pend[u] = sp; src_reg[u] = sr;
    dst_pend[u] = dp; dst_reg[u] = dr; done[u] = dn;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    src_reg = '0; dst_reg = '0; src_pend = '0; dst_pend = '0; done = '0;
    // R9: registered grants stay zero in reset despite requests
    for (int u = 0; u < N; u++) set_unit(u, 1'b1, W'(u + 3), 1'b1, W'(u + 9), 1'b1);
    repeat (3) @(negedge clk_i);
    chk("reset/R9", "rd_grant_q", 64'(rd_g_q), 64'(0));
    chk("reset/R9", "wr_grant_q", 64'(wr_g_q), 64'(0));
    chk("reset/R4", "rd_grant", 64'(rd_g), 64'(1));
    rst_ni = 1'b1;
    src_pend = '0; dst_pend = '0; done = '0;
    cycle("idle/R8");
    chk("idle/R8", "rd_grant", 64'(rd_g), 64'(0));
    chk("idle/R8", "rd_resv", 64'(rd_map), 64'(0));

    // single read by unit 2
    set_unit(2, 1'b1, 5'd7, 1'b0, 5'd0, 1'b0);
    cycle("single");
    chk("single/R4", "rd_grant", 64'(rd_g), 64'(4'b0100));

    // R3: immediate units (pend low) with nonzero numbers, overlap on reg 7
    set_unit(1, 1'b0, 5'd20, 1'b0, 5'd21, 1'b1);
    set_unit(3, 1'b1, 5'd7, 1'b0, 5'd0, 1'b0);
    cycle("imm/R3");
    chk("imm/R3", "rd_resv", 64'(rd_map), 64'(32'h0000_0080));
    chk("imm/R3", "wr_resv", 64'(wr_map), 64'(0));

    // R6: writes pending but none done: map set, no grant
    src_pend = '0;
    for (int u = 0; u < N; u++) set_unit(u, 1'b0, 5'd0, 1'b1, W'(31 - u), 1'b0);
    cycle("notdone/R6");
    chk("notdone/R6", "wr_grant", 64'(wr_g), 64'(0));
    chk("notdone/R2", "wr_resv", 64'(wr_map), 64'(32'hF000_0000));

    // R5: units 1 and 3 done, lowest done wins
    done = 4'b1010;
    cycle("prio/R5");
    chk("prio/R5", "wr_grant", 64'(wr_g), 64'(4'b0010));

    // R7: unit 1 gets both ports
    set_unit(1, 1'b1, 5'd2, 1'b1, 5'd30, 1'b1);
    set_unit(0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1);
    cycle("both/R7");
    chk("both/R7", "rd_grant", 64'(rd_g), 64'(4'b0010));
    chk("both/R7", "wr_grant", 64'(wr_g), 64'(4'b0010));

    // R7/R6: unit 0 read stuck high, random traffic elsewhere
    for (int k = 0; k < 400; k++) begin
      for (int u = 0; u < N; u++)
        set_unit(u, (u == 0) ? 1'b1 : 1'($urandom), W'($urandom), 1'($urandom),
                 W'($urandom), 1'($urandom));
      cycle("stuck/R7");
      chk("stuck/R7", "rd_grant", 64'(rd_g), 64'(1));
      chk("stuck/R6", "wr_grant_q&~prevdone", 64'(wr_g_q & ~(dst_pend & done)), 64'(0));
    end

    // R8: all quiet again
    src_pend = '0; dst_pend = '0; done = '1;
    cycle("quiet/R8");
    chk("quiet/R8", "wr_grant", 64'(wr_g), 64'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule